// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the control state for a port of general-purpose pins split into equal banks of eight. A synchronous byte-wide register bus writes an output latch, a direction mask and a drive style for every pin. It reads back the configuration and the sampled pin levels. For each pin the block produces an output value and an output enable, which feed pad drivers outside the block.

Output data is never written directly. Software first places a value byte into a per-bank staging register, then writes a mask byte to the next address. Only the latch bits selected by the mask take the staged value. Because of this, one pin can be changed without a read-modify-write of its bank. Each pin can drive both levels, drive only low, or drive only high. Pin levels are brought into the clock domain by a two-stage synchroniser before they can be read. A control bit, set at reset, keeps the whole port at its defaults until software clears it.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the hold bit (address 0x30, bit 0) reads 1. Every output latch, direction, mode-select and mode-enable bit is 0, and pin_out and pin_oe are all 0.
- R2: While the hold bit is 1, the bank registers and the input synchroniser are held at 0. Bank register writes have no effect, and reads of the data addresses return 0. Setting the hold bit again returns the bank registers to their defaults on the same clock edge that writes it.
- R3: A write to address 0x00+2b stores a staged value for bank b. A later write to 0x01+2b sets output latch bits to the staged value where the written mask bit is 1. Bits where the mask is 0 keep their value, and no other write changes the latch.
- R4: Pin n belongs to bank n/8, bit n%8. pin_out[n] is that latch bit.
- R5: The direction register of bank b is at 0x10+b. A 1 makes the pin an output. A pin whose direction bit is 0 never has pin_oe set.
- R6: The mode select of bank b is at 0x20+2b and the mode enable is at 0x21+2b. For an output pin with enable 0, pin_oe is 1. With enable 1 and select 0, pin_oe is 1 only while the latch bit is 0. With enable 1 and select 1, pin_oe is 1 only while the latch bit is 1.
- R7: A read presented with bus_rd is returned on bus_rdata after the next clock edge and held until the next read. The mask addresses return the output latch. The direction, mode and hold addresses return their stored values.
- R8: A read of data address 0x00+2b returns pin_in of bank b as sampled two clock edges before the read's edge, whatever the pin's direction.
- R9: Reads of any address not named in R2 to R8 return 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 24 | Pin levels from the pads |
| pin_out | output | 24 | Output latch per pin |
| pin_oe | output | 24 | Output enable per pin |

## Verification
The masked update is tested with three mask patterns on bank 0: a partial low nibble, a complementary high nibble, and an all-zero mask that must leave the latch unchanged. This separates "mask selects" from "mask ignored" and "mask inverted". Single-bit updates in banks 1 and 2 show that bank and bit placement are correct. Drive style is tested with all-push-pull, all-open-drain and all-open-source settings, and with a split byte of open-source and open-drain. Together these show that the mode bit and the enable bit act independently per pin. Input reads use distinct bytes per bank and a read made right after the pins change, which shows the synchroniser delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W     = 8;
  localparam int BANK_IDX_W = 3;

  // Upper address nibble selects the register group
  typedef enum logic [3:0] {
    GRP_DATA = 4'h0,
    GRP_DIR  = 4'h1,
    GRP_MODE = 4'h2,
    GRP_CTRL = 4'h3
  } reg_grp_e;

  typedef struct packed {
    logic                  val;   // staged value byte
    logic                  mask;  // mask byte that commits the staged value
    logic                  dir;
    logic                  msel;
    logic                  men;
    logic                  ctrl;
    logic [BANK_IDX_W-1:0] bank;
  } reg_sel_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_out_n = chain_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st_q [STAGES];
  logic [WIDTH-1:0] st_d [STAGES];

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      if (clr)         st_d[i] = '0;
      else if (i == 0) st_d[i] = d;
      else             st_d[i] = st_q[(i > 0) ? i - 1 : 0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam logic [3:0] BANKS4 = 4'(NUM_BANKS);

  logic [3:0] off;
  assign off = addr[3:0];

  always_comb begin
    sel = '0;
    case (reg_grp_e'(addr[7:4]))
      GRP_DATA: if ({1'b0, off[3:1]} < BANKS4) begin
        sel.bank = off[3:1];
        sel.val  = ~off[0];
        sel.mask = off[0];
      end
      GRP_DIR: if (off < BANKS4) begin
        sel.bank = off[2:0];
        sel.dir  = 1'b1;
      end
      GRP_MODE: if ({1'b0, off[3:1]} < BANKS4) begin
        sel.bank = off[3:1];
        sel.msel = ~off[0];
        sel.men  = off[0];
      end
      GRP_CTRL: sel.ctrl = (off == 4'h0);
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_val,
  input  logic              wr_mask,
  input  logic              wr_dir,
  input  logic              wr_msel,
  input  logic              wr_men,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] out_q,
  output logic [LANE_W-1:0] dir_q,
  output logic [LANE_W-1:0] msel_q,
  output logic [LANE_W-1:0] men_q,
  output logic [LANE_W-1:0] oe
);
  logic [LANE_W-1:0] stage_q, stage_d, out_d, dir_d, msel_d, men_d;
  logic              upd_en;

  assign upd_en = hold | wr_val | wr_mask | wr_dir | wr_msel | wr_men;

  always_comb begin
    stage_d = stage_q;
    out_d   = out_q;
    dir_d   = dir_q;
    msel_d  = msel_q;
    men_d   = men_q;
    if (hold) begin
      stage_d = '0;
      out_d   = '0;
      dir_d   = '0;
      msel_d  = '0;
      men_d   = '0;
    end else begin
      if (wr_val)  stage_d = wdata;
      if (wr_mask) out_d   = (out_q & ~wdata) | (stage_q & wdata);
      if (wr_dir)  dir_d   = wdata;
      if (wr_msel) msel_d  = wdata;
      if (wr_men)  men_d   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
      dir_q   <= '0;
      msel_q  <= '0;
      men_q   <= '0;
    end else if (upd_en) begin
      stage_q <= stage_d;
      out_q   <= out_d;
      dir_q   <= dir_d;
      msel_q  <= msel_d;
      men_q   <= men_d;
    end
  end

  // Enabled single-ended pins drive only in their active level
  assign oe = dir_q & (~men_q | (msel_q & out_q) | (~msel_q & ~out_q));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_port_pkg::*;
#(
  parameter  int NUM_BANKS = 3,
  parameter  int LANE_W    = 8,
  localparam int NPINS     = NUM_BANKS * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [LANE_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic       rst_int_n;
  reg_sel_t   sel;
  logic       hold_q, hold_d, hold_en;
  logic [NPINS-1:0] pin_sync, dir_all, msel_all, men_all;
  logic [LANE_W-1:0] out_b [NUM_BANKS];
  logic [LANE_W-1:0] dir_b [NUM_BANKS];
  logic [LANE_W-1:0] msel_b[NUM_BANKS];
  logic [LANE_W-1:0] men_b [NUM_BANKS];
  logic [LANE_W-1:0] sync_b[NUM_BANKS];
  logic [LANE_W-1:0] rd_mux, rdata_q;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_out_n(rst_int_n));

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (.addr(bus_addr), .sel(sel));

  // Port hold control
  assign hold_en = bus_wr & sel.ctrl;
  always_comb begin
    hold_d = hold_q;
    if (hold_en) hold_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= 1'b1;
    else if (!rst_int_n) hold_q <= 1'b1;
    else if (hold_en)    hold_q <= hold_d;
  end

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .clr(hold_d), .d(pin_in), .q(pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    logic [LANE_W-1:0] oe_b;
    assign hit = bus_wr & (sel.bank == BANK_IDX_W'(b));

    gpio_bank #(.LANE_W(LANE_W)) u_bank (
      .clk(clk), .rst_n(rst_int_n), .hold(hold_d),
      .wr_val(hit & sel.val), .wr_mask(hit & sel.mask), .wr_dir(hit & sel.dir),
      .wr_msel(hit & sel.msel), .wr_men(hit & sel.men), .wdata(bus_wdata),
      .out_q(out_b[b]), .dir_q(dir_b[b]), .msel_q(msel_b[b]), .men_q(men_b[b]),
      .oe(oe_b)
    );

    assign sync_b[b]                       = pin_sync[b*LANE_W +: LANE_W];
    assign pin_out [b*LANE_W +: LANE_W]    = out_b[b];
    assign pin_oe  [b*LANE_W +: LANE_W]    = oe_b;
    assign dir_all [b*LANE_W +: LANE_W]    = dir_b[b];
    assign msel_all[b*LANE_W +: LANE_W]    = msel_b[b];
    assign men_all [b*LANE_W +: LANE_W]    = men_b[b];
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (sel.val)       rd_mux = sync_b[sel.bank];
    else if (sel.mask) rd_mux = out_b[sel.bank];
    else if (sel.dir)  rd_mux = dir_b[sel.bank];
    else if (sel.msel) rd_mux = msel_b[sel.bank];
    else if (sel.men)  rd_mux = men_b[sel.bank];
    else if (sel.ctrl) rd_mux = LANE_W'(hold_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int NUM_BANKS = 3,
  parameter int LANE_W    = 8,
  localparam int NPINS    = NUM_BANKS * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic [LANE_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [LANE_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              hold_q,
  input logic [NPINS-1:0]  dir_all,
  input logic [NPINS-1:0]  msel_all,
  input logic [NPINS-1:0]  men_all
);
  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pin_out == '0 && pin_oe == '0));

  p_idle_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out));

  p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h01 && !hold_q) |=>
      ((pin_out[LANE_W-1:0] ^ $past(pin_out[LANE_W-1:0])) & ~$past(bus_wdata)) == '0);

  p_oe_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_all) == '0);

  p_push_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ dir_all) & ~men_all) == '0);

  p_open_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & men_all & ~msel_all & pin_out) == '0);

  p_open_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & men_all & msel_all & ~pin_out) == '0);

  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:6] != 2'b00) |=> bus_rdata == '0);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_BANKS(NUM_BANKS), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .hold_q(hold_q),
  .dir_all(dir_all), .msel_all(msel_all), .men_all(men_all)
);

// File: tb/sim_gpio_bank_regs.sv
`timescale 1ns/1ps
module sim_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference model
  logic [23:0] m_out, m_dir, m_msel, m_men, m_s1, m_s2;
  logic [7:0]  m_stage [3];
  logic [7:0]  m_rdata;
  logic        m_hold;
  int          m_rcnt;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int b;
    if (a < 8'h06) begin
      b = a / 2;
      return (a % 2 == 0) ? m_s2[b*8 +: 8] : m_out[b*8 +: 8];
    end
    if (a >= 8'h10 && a < 8'h13) return m_dir[(a - 8'h10)*8 +: 8];
    if (a >= 8'h20 && a < 8'h26) begin
      b = (a - 8'h20) / 2;
      return (a % 2 == 0) ? m_msel[b*8 +: 8] : m_men[b*8 +: 8];
    end
    if (a == 8'h30) return {7'd0, m_hold};
    return 8'h00;
  endfunction

  function automatic logic [23:0] m_oe();
    logic [23:0] r;
    for (int i = 0; i < 24; i++) begin
      if (!m_dir[i])      r[i] = 1'b0;
      else if (!m_men[i]) r[i] = 1'b1;
      else if (m_msel[i]) r[i] = m_out[i];
      else                r[i] = ~m_out[i];
    end
    return r;
  endfunction

  task automatic m_clear();
    m_out = '0; m_dir = '0; m_msel = '0; m_men = '0;
    for (int b = 0; b < 3; b++) m_stage[b] = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt = m_rcnt + 1;
      m_clear();
      m_s1 = '0; m_s2 = '0; m_rdata = '0; m_hold = 1'b1;
    end else begin
      logic nh;
      nh = m_hold;
      if (bus_wr && bus_addr == 8'h30) nh = bus_wdata[0];
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (nh) begin
        m_s2 = '0; m_s1 = '0; m_clear();
      end else begin
        m_s2 = m_s1; m_s1 = pin_in;
        if (bus_wr) begin
          if (bus_addr < 8'h06) begin
            int b;
            b = bus_addr / 2;
            if (bus_addr % 2 == 0) m_stage[b] = bus_wdata;
            else m_out[b*8 +: 8] = (m_out[b*8 +: 8] & ~bus_wdata) | (m_stage[b] & bus_wdata);
          end else if (bus_addr >= 8'h10 && bus_addr < 8'h13) begin
            m_dir[(bus_addr - 8'h10)*8 +: 8] = bus_wdata;
          end else if (bus_addr >= 8'h20 && bus_addr < 8'h26) begin
            int b;
            b = (bus_addr - 8'h20) / 2;
            if (bus_addr % 2 == 0) m_msel[b*8 +: 8] = bus_wdata;
            else m_men[b*8 +: 8] = bus_wdata;
          end
        end
      end
      m_hold = nh;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R3/R4 pin_out vs model", 32'(pin_out), 32'(m_out));
      check("R6 pin_oe vs model", 32'(pin_oe), 32'(m_oe()));
      check("R7 bus_rdata vs model", 32'(bus_rdata), 32'(m_rdata));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 reset state
    check("R1 pin_out after reset", 32'(pin_out), 0);
    check("R1 pin_oe after reset", 32'(pin_oe), 0);
    rd(8'h30, v); check("R1 hold bit set", 32'(v), 1);
    rd(8'h10, v); check("R1 direction zero", 32'(v), 0);
    rd(8'h21, v); check("R1 mode enable zero", 32'(v), 0);

    // R2 writes ignored while held
    pin_in = 24'h123456;
    wr(8'h10, 8'hFF);
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF);
    rd(8'h10, v); check("R2 direction held", 32'(v), 0);
    rd(8'h01, v); check("R2 latch held", 32'(v), 0);
    check("R2 oe off while held", 32'(pin_oe), 0);
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R2 data read zero while held", 32'(v), 0);

    wr(8'h30, 8'h00);
    rd(8'h30, v); check("R2 hold released", 32'(v), 0);

    // R3 masked update
    wr(8'h00, 8'hA5); wr(8'h01, 8'h0F);
    rd(8'h01, v); check("R3 partial mask", 32'(v), 32'h05);
    wr(8'h00, 8'hFF); wr(8'h01, 8'hF0);
    check("R3 second mask", 32'(pin_out[7:0]), 32'hF5);
    wr(8'h00, 8'h00); wr(8'h01, 8'h00);
    check("R3 zero mask keeps latch", 32'(pin_out[7:0]), 32'hF5);

    // R4 pin mapping
    wr(8'h04, 8'h80); wr(8'h05, 8'h80);
    check("R4 pin 23", 32'(pin_out[23:16]), 32'h80);
    wr(8'h02, 8'h02); wr(8'h03, 8'h02);
    check("R4 pin 9", 32'(pin_out), 32'h8002F5);

    // R5 direction
    check("R5 inputs do not drive", 32'(pin_oe), 0);
    wr(8'h10, 8'hFF);
    check("R5 bank0 outputs", 32'(pin_oe[7:0]), 32'hFF);
    wr(8'h11, 8'h0F);
    check("R5 bank1 partial", 32'(pin_oe), 32'h000FFF);

    // R6 drive styles on bank 0 (latch F5)
    wr(8'h20, 8'h00); wr(8'h21, 8'hFF);
    check("R6 open-drain", 32'(pin_oe[7:0]), 32'h0A);
    wr(8'h20, 8'hFF);
    check("R6 open-source", 32'(pin_oe[7:0]), 32'hF5);
    wr(8'h20, 8'h0F);
    check("R6 split styles", 32'(pin_oe[7:0]), 32'h05);
    wr(8'h21, 8'h00);
    check("R6 push-pull", 32'(pin_oe[7:0]), 32'hFF);

    // R7 readback
    rd(8'h20, v); check("R7 mode select readback", 32'(v), 32'h0F);
    rd(8'h11, v); check("R7 direction readback", 32'(v), 32'h0F);
    @(negedge clk);
    check("R7 rdata held without read", 32'(bus_rdata), 32'h0F);

    // R8 synchronised inputs
    rd(8'h00, v); check("R8 bank0 input", 32'(v), 32'h56);
    pin_in = 24'hABCDEF;
    rd(8'h00, v); check("R8 old value right after change", 32'(v), 32'h56);
    repeat (2) @(negedge clk);
    rd(8'h00, v); check("R8 bank0 output pin read", 32'(v), 32'hEF);
    rd(8'h02, v); check("R8 bank1 input", 32'(v), 32'hCD);
    rd(8'h04, v); check("R8 bank2 input", 32'(v), 32'hAB);

    // R9 unmapped addresses
    wr(8'h06, 8'hFF); wr(8'h07, 8'hFF); wr(8'h13, 8'hFF);
    wr(8'h26, 8'hFF); wr(8'h31, 8'hFF); wr(8'h40, 8'hFF);
    check("R9 latch untouched", 32'(pin_out), 32'h8002F5);
    check("R9 oe untouched", 32'(pin_oe), 32'h000FFF);
    rd(8'h13, v); check("R9 read 0x13", 32'(v), 0);
    rd(8'h31, v); check("R9 read 0x31", 32'(v), 0);
    rd(8'h40, v); check("R9 read 0x40", 32'(v), 0);
    rd(8'h30, v); check("R9 hold untouched", 32'(v), 0);

    // R2 re-entering hold clears the port
    wr(8'h30, 8'h01);
    check("R2 outputs cleared on hold", 32'(pin_out), 0);
    check("R2 oe cleared on hold", 32'(pin_oe), 0);
    wr(8'h30, 8'h00);
    rd(8'h10, v); check("R2 direction default after hold", 32'(v), 0);
    rd(8'h01, v); check("R2 latch default after hold", 32'(v), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule